// File: doc/BRIEF.md
# Variable-step piecewise-linear square-root evaluator

This block approximates a smooth, nondecreasing function, chiefly the square root of a normalised operand, by straight-line interpolation between node points held in a small constant table. The input domain is split into regions. Inside one region every segment has the same power-of-two length, and different regions may use different lengths. Curved stretches of the function get short segments and flat stretches get long ones, which keeps the table small for a given accuracy.

A bank of magnitude comparators, one per region start, finds the region that holds the input. The comparator result selects the table base, the split of the input into a segment index and an in-segment offset, and the right-shift that stands in for division by the segment length. One pair of adjacent nodes is read, and the output is formed with one subtract, one multiply, a half-up rounding add and one shift. This path is purely combinational, and its result is registered one clock edge after the input is presented.

With the default parameters the input code `x` (10 bits) stands for the value x/256, and the output code `y` (10 bits) stands for y/256. The default layout has regions starting at 256, 320 and 512, with segment lengths 16, 32 and 64. That gives 18 segments and 19 node values, where node value = round(sqrt(256·x_node)). The node values are computed at elaboration time.

Top module: `pwl_eval`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and y_o is 0.
- R2: valid_o equals the valid_i sampled on the previous rising edge. The y_o captured on that edge belongs to the x_i sampled with it.
- R3: When valid_i is low on an edge, y_o keeps its previous value whatever x_i carries.
- R4: For every input code 256..1023, y_o differs from round(sqrt(256·x)) by at most 1.
- R5: For an input at a segment start, y_o equals round(sqrt(256·x)) exactly. With the default layout the segment starts are 256+16j below 320, 320+32j below 512, and 512+64j below 1024.
- R6: An input code below the first region start (below 256) produces y_o = 256, the value of the first node.
- R7: Over the input codes 0..1023 taken in increasing order, y_o never decreases, including across region boundaries.
- R8: y_o lies between the node values of the two ends of the segment that holds x.
- R9: Inside a segment of length L = 2^k starting at s, y_o = n_s + floor(((n_{s+L} − n_s)·(x − s) + L/2) / L), where n_v = round(sqrt(256·v)).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word present this cycle |
| x_i | input | IN_W | Unsigned fixed-point operand |
| valid_o | output | 1 | y_o updated on the last edge |
| y_o | output | OUT_W | Approximated function value |

## Verification
The hardest situation to reach from the ports is the comparator hand-over at a region boundary. There the segment length, the shift and the table base all change between two adjacent codes, and an off-by-one in the base or the mask shows up only on the last code of one region or the first code of the next. The stimulus sweeps every input code in increasing order and checks each result against the exact interpolation formula and the monotonic rule. It then adds directed codes on each side of every region start, the codes below the domain, and seeded random codes interleaved with idle cycles so that the hold behaviour is exercised while x_i keeps changing.

// File: rtl/pwl_pkg.sv
package pwl_pkg;

  // floor(sqrt(n)), bitwise from the top
  function automatic longint unsigned isqrt_floor(longint unsigned n);
    longint unsigned r;
    longint unsigned t;
    r = 0;
    for (int b = 31; b >= 0; b--) begin
      t = r | (64'd1 << b);
      if (t * t <= n) r = t;
    end
    return r;
  endfunction

  // round-to-nearest integer square root
  function automatic int unsigned isqrt_round(longint unsigned n);
    longint unsigned f;
    f = isqrt_floor(n);
    if (n > f * f + f) f = f + 1;
    return 32'(f);
  endfunction

endpackage

// File: rtl/pwl_seg_decoder.sv
module pwl_seg_decoder #(
  parameter int unsigned IN_W     = 10,
  parameter int unsigned NUM_REG  = 3,
  parameter int unsigned REG_START [NUM_REG] = '{32'd256, 32'd320, 32'd512},
  parameter int unsigned REG_LOG2  [NUM_REG] = '{32'd4, 32'd5, 32'd6},
  parameter int unsigned MAX_LOG2 = 6,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned SH_W     = 3
) (
  input  logic [IN_W-1:0]     x_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [MAX_LOG2-1:0] dx_o,
  output logic [SH_W-1:0]     shift_o
);

  function automatic int unsigned seg_cnt(int unsigned q);
    int unsigned stop;
    stop = (q == NUM_REG - 1) ? (32'd1 << IN_W) : REG_START[q+1];
    return (stop - REG_START[q]) >> REG_LOG2[q];
  endfunction

  // one comparator per region start; thermometer result
  logic [NUM_REG-1:0] ge;
  for (genvar r = 0; r < NUM_REG; r++) begin : g_cmp
    assign ge[r] = x_i >= IN_W'(REG_START[r]);
  end

  always_comb begin
    int unsigned sel;
    int unsigned base;
    int unsigned k;
    int unsigned off;
    int unsigned msk;
    sel = 0;
    for (int unsigned r = 1; r < NUM_REG; r++) begin
      if (ge[r]) sel = r;
    end
    base = 0;
    for (int unsigned q = 0; q < NUM_REG; q++) begin
      if (q < sel) base = base + seg_cnt(q);
    end
    k   = REG_LOG2[sel];
    off = 32'(x_i) - REG_START[sel];
    msk = (32'd1 << k) - 32'd1;
    if (!ge[0]) begin
      // below domain: clamp to first node
      addr_o  = '0;
      dx_o    = '0;
      shift_o = '0;
    end else begin
      addr_o  = ADDR_W'(base + (off >> k));
      dx_o    = MAX_LOG2'(off & msk);
      shift_o = SH_W'(k);
    end
  end

endmodule

// File: rtl/pwl_node_rom.sv
module pwl_node_rom #(
  parameter int unsigned IN_W     = 10,
  parameter int unsigned OUT_W    = 10,
  parameter int unsigned SQ_SHIFT = 8,
  parameter int unsigned NUM_REG  = 3,
  parameter int unsigned REG_START [NUM_REG] = '{32'd256, 32'd320, 32'd512},
  parameter int unsigned REG_LOG2  [NUM_REG] = '{32'd4, 32'd5, 32'd6},
  parameter int unsigned N_NODES  = 19,
  parameter int unsigned ADDR_W   = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [OUT_W-1:0]  y_lo_o,
  output logic [OUT_W-1:0]  y_hi_o
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  function automatic int unsigned seg_cnt(int unsigned q);
    int unsigned stop;
    stop = (q == NUM_REG - 1) ? (32'd1 << IN_W) : REG_START[q+1];
    return (stop - REG_START[q]) >> REG_LOG2[q];
  endfunction

  // input code at which node a sits
  function automatic int unsigned node_x(int unsigned a);
    int unsigned idx;
    int unsigned res;
    bit          hit;
    idx = a;
    res = 32'd1 << IN_W;
    hit = 1'b0;
    for (int unsigned q = 0; q < NUM_REG; q++) begin
      if (!hit) begin
        if (idx < seg_cnt(q)) begin
          res = REG_START[q] + (idx << REG_LOG2[q]);
          hit = 1'b1;
        end else begin
          idx = idx - seg_cnt(q);
        end
      end
    end
    return res;
  endfunction

  logic [OUT_W-1:0] tbl [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_node
    localparam int unsigned AA = (a < N_NODES) ? a : N_NODES - 1;
    localparam int unsigned NX = node_x(AA);
    localparam int unsigned NY = pwl_pkg::isqrt_round(64'(NX) << SQ_SHIFT);
    assign tbl[a] = OUT_W'(NY);
  end

  assign y_lo_o = tbl[addr_i];
  assign y_hi_o = tbl[addr_i + ADDR_W'(1)];

endmodule

// File: rtl/pwl_interp.sv
module pwl_interp #(
  parameter int unsigned OUT_W    = 10,
  parameter int unsigned MAX_LOG2 = 6,
  parameter int unsigned SH_W     = 3
) (
  input  logic [OUT_W-1:0]    y_lo_i,
  input  logic [OUT_W-1:0]    y_hi_i,
  input  logic [MAX_LOG2-1:0] dx_i,
  input  logic [SH_W-1:0]     shift_i,
  output logic [OUT_W-1:0]    y_o
);

  localparam int unsigned P_W = OUT_W + MAX_LOG2;

  logic [OUT_W-1:0] dy;
  logic [P_W-1:0]   prod;
  logic [P_W-1:0]   bias;
  logic [P_W-1:0]   frac;

  assign dy   = y_hi_i - y_lo_i;
  assign prod = P_W'(dy) * P_W'(dx_i);
  // half-LSB rounding ahead of the variable shift
  assign bias = (shift_i == '0) ? '0 : (P_W'(1) << (shift_i - SH_W'(1)));
  assign frac = (prod + bias) >> shift_i;
  assign y_o  = y_lo_i + OUT_W'(frac);

endmodule

// File: rtl/pwl_eval.sv
module pwl_eval
  import pwl_pkg::*;
#(
  parameter int unsigned IN_W     = 10,
  parameter int unsigned OUT_W    = 10,
  parameter int unsigned SQ_SHIFT = 8,
  parameter int unsigned NUM_REG  = 3,
  parameter int unsigned REG_START [NUM_REG] = '{32'd256, 32'd320, 32'd512},
  parameter int unsigned REG_LOG2  [NUM_REG] = '{32'd4, 32'd5, 32'd6},
  parameter int unsigned MAX_LOG2 = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [IN_W-1:0]  x_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] y_o
);

  function automatic int unsigned total_nodes();
    int unsigned s;
    int unsigned stop;
    s = 0;
    for (int unsigned q = 0; q < NUM_REG; q++) begin
      stop = (q == NUM_REG - 1) ? (32'd1 << IN_W) : REG_START[q+1];
      s = s + ((stop - REG_START[q]) >> REG_LOG2[q]);
    end
    return s + 1;
  endfunction

  localparam int unsigned N_NODES = total_nodes();
  localparam int unsigned ADDR_W  = $clog2(N_NODES);
  localparam int unsigned SH_W    = $clog2(MAX_LOG2 + 1);

  logic [ADDR_W-1:0]   addr_w;
  logic [MAX_LOG2-1:0] dx_w;
  logic [SH_W-1:0]     shift_w;
  logic [OUT_W-1:0]    y_lo_w;
  logic [OUT_W-1:0]    y_hi_w;
  logic [OUT_W-1:0]    res_w;

  pwl_seg_decoder #(
    .IN_W     (IN_W),
    .NUM_REG  (NUM_REG),
    .REG_START(REG_START),
    .REG_LOG2 (REG_LOG2),
    .MAX_LOG2 (MAX_LOG2),
    .ADDR_W   (ADDR_W),
    .SH_W     (SH_W)
  ) dec_i (
    .x_i    (x_i),
    .addr_o (addr_w),
    .dx_o   (dx_w),
    .shift_o(shift_w)
  );

  pwl_node_rom #(
    .IN_W     (IN_W),
    .OUT_W    (OUT_W),
    .SQ_SHIFT (SQ_SHIFT),
    .NUM_REG  (NUM_REG),
    .REG_START(REG_START),
    .REG_LOG2 (REG_LOG2),
    .N_NODES  (N_NODES),
    .ADDR_W   (ADDR_W)
  ) rom_i (
    .addr_i(addr_w),
    .y_lo_o(y_lo_w),
    .y_hi_o(y_hi_w)
  );

  pwl_interp #(
    .OUT_W   (OUT_W),
    .MAX_LOG2(MAX_LOG2),
    .SH_W    (SH_W)
  ) interp_i (
    .y_lo_i (y_lo_w),
    .y_hi_i (y_hi_w),
    .dx_i   (dx_w),
    .shift_i(shift_w),
    .y_o    (res_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      y_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) y_o <= res_w;
    end
  end

endmodule

// File: rtl/pwl_eval_chk.sv
module pwl_eval_chk #(
  parameter int unsigned OUT_W    = 10,
  parameter int unsigned MAX_LOG2 = 6,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned N_NODES  = 19
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic                valid_o,
  input logic [OUT_W-1:0]    y_o,
  input logic [ADDR_W-1:0]   addr_w,
  input logic [MAX_LOG2-1:0] dx_w,
  input logic [OUT_W-1:0]    y_lo_w,
  input logic [OUT_W-1:0]    y_hi_w,
  input logic [OUT_W-1:0]    res_w
);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R1: assert (!valid_o && y_o == '0);
    end
  end

  assert_valid_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_valid_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  assert_hold_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(y_o));

  assert_node_exact_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dx_w == '0) |-> (res_w == y_lo_w));

  assert_bracket_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_w >= y_lo_w) && (res_w <= y_hi_w));

  assert_addr_in_table_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(addr_w) <= N_NODES - 2);

endmodule

bind pwl_eval pwl_eval_chk #(
  .OUT_W   (OUT_W),
  .MAX_LOG2(MAX_LOG2),
  .ADDR_W  (ADDR_W),
  .N_NODES (N_NODES)
) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .valid_o(valid_o),
  .y_o    (y_o),
  .addr_w (addr_w),
  .dx_w   (dx_w),
  .y_lo_w (y_lo_w),
  .y_hi_w (y_hi_w),
  .res_w  (res_w)
);

// File: tb/pwl_eval_tb_top.sv
`timescale 1ns/1ps
module pwl_eval_tb_top;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       valid_i;
  logic [9:0] x_i;
  logic       valid_o;
  logic [9:0] y_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk_i = ~clk_i;

  pwl_eval dut_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .x_i    (x_i),
    .valid_o(valid_o),
    .y_o    (y_o)
  );

  function automatic int ref_round(int v);
    longint n;
    longint r;
    n = longint'(v) * 256;
    r = 0;
    while ((r + 1) * (r + 1) <= n) r++;
    if (n > r * r + r) r++;
    return int'(r);
  endfunction

  function automatic int seg_len(int v);
    if (v < 320) return 16;
    if (v < 512) return 32;
    return 64;
  endfunction

  function automatic int seg_start(int v);
    return v - (v % seg_len(v));
  endfunction

  function automatic int expect_y(int v);
    int s, l, lo, hi;
    if (v < 256) return 256;
    s  = seg_start(v);
    l  = seg_len(v);
    lo = ref_round(s);
    hi = ref_round(s + l);
    return lo + (((hi - lo) * (v - s) + l / 2) / l);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input int v);
    @(negedge clk_i);
    x_i     = 10'(v);
    valid_i = 1'b1;
    @(posedge clk_i);
    #1;
  endtask

  // full check of one result
  task automatic check_full(input int v);
    int e, r;
    chk(valid_o === 1'b1, "R2 valid", int'(valid_o), 1);
    e = expect_y(v);
    chk(int'(y_o) == e, "R9 interp", int'(y_o), e);
    if (v < 256) begin
      chk(int'(y_o) == 256, "R6 below domain", int'(y_o), 256);
    end else begin
      r = ref_round(v);
      chk((int'(y_o) - r <= 1) && (r - int'(y_o) <= 1), "R4 accuracy", int'(y_o), r);
      if (v == seg_start(v))
        chk(int'(y_o) == r, "R5 node exact", int'(y_o), r);
      chk(int'(y_o) >= ref_round(seg_start(v)) &&
          int'(y_o) <= ref_round(seg_start(v) + seg_len(v)),
          "R8 bracket", int'(y_o), ref_round(seg_start(v)));
    end
  endtask

  task automatic idle_check(input int junk);
    int held;
    held = int'(y_o);
    @(negedge clk_i);
    valid_i = 1'b0;
    x_i     = 10'(junk);
    @(posedge clk_i);
    #1;
    chk(valid_o === 1'b0, "R2 valid low", int'(valid_o), 0);
    chk(int'(y_o) == held, "R3 hold", int'(y_o), held);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int prev;
    rst_ni  = 1'b0;
    valid_i = 1'b0;
    x_i     = '0;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk_i);
    #1;
    chk(valid_o === 1'b0 && y_o === '0, "R1 reset", int'(y_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R7 ascending sweep of every code
    prev = 0;
    for (int v = 0; v < 1024; v++) begin
      apply(v);
      check_full(v);
      chk(int'(y_o) >= prev, "R7 monotonic", int'(y_o), prev);
      prev = int'(y_o);
    end

    // region hand-over and domain edges
    begin
      int edges [12] = '{255, 256, 257, 319, 320, 321, 511, 512, 513, 1023, 0, 288};
      foreach (edges[i]) begin
        apply(edges[i]);
        check_full(edges[i]);
      end
    end

    // R3 idle cycles with changing input
    apply(700);
    check_full(700);
    idle_check(100);
    idle_check(1000);
    apply(320);
    check_full(320);
    idle_check(511);

    // seeded random mix
    for (int i = 0; i < 3000; i++) begin
      int v;
      v = int'($urandom_range(1023, 0));
      apply(v);
      check_full(v);
      if ((i % 97) == 0) idle_check(int'($urandom_range(1023, 0)));
    end

    // R1 asynchronous reset mid-run
    apply(900);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(valid_o === 1'b0 && y_o === '0, "R1 async reset", int'(y_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    apply(600);
    check_full(600);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule